// File: doc/BRIEF.md
# I2C Slave Byte Transmitter with Host Pacing

This block is the target side of an I2C link that answers read requests. It watches the bus for a start condition, takes in the first eight bits as an address frame and compares the upper seven bits with a programmed address. When the address matches and the direction bit asks for a read, the block acknowledges and switches itself into transmit mode. It then sends bytes that a local host places into a data register.

After every byte the block raises a flag and holds SCL low. The master therefore waits until the host has supplied the next byte and cleared the flag. The acknowledge that the master returns after each byte is stored where the host can read it.

When the master refuses a byte (NACK), the host ends the transfer. It clears transmit mode, then performs one dummy read of the data register, and only that read lets go of SCL. Both bus pins are open-drain: an output of 1 means the block pulls that line low.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset both line drivers are off (`scl_oe`=0, `sda_oe`=0), and `tx_mode`=0 and `byte_irq`=0.
- R2: If the address frame after a start has bits [7:1] equal to `own_addr` and bit [0]=1 (read), the block pulls SDA low during the 9th clock. On the falling edge of that clock it sets `tx_mode` and `byte_irq` and starts holding SCL low.
- R3: If bits [7:1] of the address frame differ from `own_addr`, SDA stays released during the 9th clock and for the rest of the frame. `byte_irq` and `tx_mode` stay 0, and SCL is not held.
- R4: If the address matches with bit [0]=0 (write), the block acknowledges the address, leaves `tx_mode` and `byte_irq` at 0, and ignores the following byte without acknowledging it.
- R5: Transmit bytes leave most significant bit first. SDA changes only while SCL is low, except when a start or stop condition resets it.
- R6: At the falling edge of each byte's acknowledge clock, `byte_irq` rises and SCL is held low. Once the host clears `byte_irq`, with `tx_mode`=1 and an acknowledged previous byte, the block loads the current data register as the next byte and releases SCL.
- R7: The SDA level that the master returns during the acknowledge clock is captured into `peer_nack` on that clock's rising edge (0 = ACK, 1 = NACK).
- R8: After a NACK, neither clearing `byte_irq` nor a data read while `tx_mode`=1 releases SCL. SCL is released only by a data read (`host_rd`) once `tx_mode`=0.
- R9: A stop condition (SDA rising while SCL is high), at any point, releases both lines, clears `tx_mode`, and returns the block to idle.
- R10: A start condition in the middle of a frame restarts address reception, and a matching read address that follows is handled as in R2.
- R11: `host_rdata` returns the value most recently written with `host_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Programmed slave address |
| host_wr | input | 1 | Data register write strobe |
| host_wdata | input | DATA_W | Data to write |
| host_rd | input | 1 | Data register read strobe |
| host_rdata | output | DATA_W | Data register contents |
| tx_mode_clr | input | 1 | Host strobe that clears transmit mode |
| tx_mode | output | 1 | Transmit mode bit |
| byte_irq | output | 1 | Per-byte interrupt flag |
| irq_clr | input | 1 | Strobe that clears `byte_irq` |
| peer_nack | output | 1 | Last acknowledge from the master (1 = NACK) |

## Verification
The hardest state to reach is the end-of-transfer hold. In it the master has sent a NACK and SCL stays pulled low, while the host works through clearing the flag, a premature data read and the transmit-mode clear, and each step must leave the line held. The bench reaches this state with a bit-level master model that honours clock stretching. It reads two bytes and NACKs the second. The host strobes then arrive one at a time while the master itself holds SCL low, so the `scl_oe` port alone shows whether the block still holds the line. A stop in the middle of a byte and a repeated start in the middle of an address cover the paths that abort a transfer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int FRAME_W = 8;
  localparam int ADDR_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_TACK,
    ST_HOLD
  } st_e;

  // true when the upper seven bits of the frame equal the programmed address
  function automatic logic frame_hits(input logic [FRAME_W-1:0] frame,
                                      input logic [ADDR_W-1:0] own);
    return frame[FRAME_W-1:1] == own;
  endfunction

  // direction bit: 1 asks the slave to send
  function automatic logic frame_reads(input logic [FRAME_W-1:0] frame);
    return frame[0];
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_cur,
  output logic sda_cur,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= (g == 0) ? scl_i : scl_pipe[(g == 0) ? 0 : g-1];
          sda_pipe[g] <= (g == 0) ? sda_i : sda_pipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_cur = scl_pipe[STAGES-1];
  assign sda_cur = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_cur;
      sda_prev <= sda_cur;
    end
  end

  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_evt = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_evt  = scl_cur & scl_prev & ~sda_prev & sda_cur;
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              tx_mode_clr,
  input  logic              irq_clr,
  input  logic              stop_evt,
  input  logic              rd_hit,
  input  logic              byte_evt,
  input  logic              ack_evt,
  input  logic              ack_val,
  output logic [DATA_W-1:0] data_q,
  output logic              tx_mode,
  output logic              byte_irq,
  output logic              peer_nack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      tx_mode   <= 1'b0;
      byte_irq  <= 1'b0;
      peer_nack <= 1'b0;
    end else begin
      if (host_wr) data_q <= host_wdata;

      if (stop_evt)         tx_mode <= 1'b0;
      else if (rd_hit)      tx_mode <= 1'b1;
      else if (tx_mode_clr) tx_mode <= 1'b0;

      if (byte_evt)     byte_irq <= 1'b1;
      else if (irq_clr) byte_irq <= 1'b0;

      if (ack_evt) peer_nack <= ack_val;
    end
  end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_cur,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic [ADDR_W-1:0]    own_addr,
  input  logic                 tx_mode,
  input  logic                 byte_irq,
  input  logic                 host_rd,
  input  logic [DATA_W-1:0]    data_q,
  output logic                 scl_oe,
  output logic                 sda_oe,
  output logic                 rd_hit,
  output logic                 byte_evt,
  output logic                 ack_evt,
  output logic                 ack_val
);
  localparam int CNT_W = (DATA_W > FRAME_W) ? $clog2(DATA_W) : $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  st_e                st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] frame;
  logic               got_all;
  logic               rw_q;
  logic               nack_q;
  logic [DATA_W-1:0]  shreg;

  assign rd_hit   = (st == ST_AACK) && scl_fall && rw_q;
  assign byte_evt = rd_hit || ((st == ST_TACK) && scl_fall);
  assign ack_evt  = (st == ST_TACK) && scl_rise;
  assign ack_val  = sda_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      frame   <= '0;
      got_all <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      shreg   <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st      <= ST_ADDR;
      cnt     <= '0;
      got_all <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            frame <= {frame[FRAME_W-2:0], sda_cur};
            if (cnt == ADDR_LAST) got_all <= 1'b1;
            else cnt <= cnt + 1'b1;
          end
          if (scl_fall && got_all) begin
            if (frame_hits(frame, own_addr)) begin
              sda_oe <= 1'b1;
              rw_q   <= frame_reads(frame);
              st     <= ST_AACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            if (rw_q) begin
              scl_oe <= 1'b1;
              nack_q <= 1'b0;
              st     <= ST_HOLD;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == DATA_LAST) begin
              sda_oe <= 1'b0;
              st     <= ST_TACK;
            end else begin
              shreg  <= {shreg[DATA_W-2:0], 1'b0};
              sda_oe <= ~shreg[DATA_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) nack_q <= sda_cur;
          if (scl_fall) begin
            scl_oe <= 1'b1;
            st     <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (host_rd && !tx_mode) begin
            scl_oe <= 1'b0;
            st     <= ST_IDLE;
          end else if (!nack_q && tx_mode && !byte_irq) begin
            shreg  <= data_q;
            sda_oe <= ~data_q[DATA_W-1];
            scl_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [6:0]        own_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              tx_mode_clr,
  output logic              tx_mode,
  output logic              byte_irq,
  input  logic              irq_clr,
  output logic              peer_nack
);
  // named internal events, also used by the bound checker
  logic scl_cur, sda_cur, scl_rise, scl_fall, start_evt, stop_evt;
  logic rd_hit, byte_evt, ack_evt, ack_val;
  logic [DATA_W-1:0] data_q;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_cur(scl_cur), .sda_cur(sda_cur), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_cur(sda_cur), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(own_addr), .tx_mode(tx_mode), .byte_irq(byte_irq),
    .host_rd(host_rd), .data_q(data_q), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rd_hit(rd_hit), .byte_evt(byte_evt), .ack_evt(ack_evt), .ack_val(ack_val)
  );

  i2cs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .tx_mode_clr(tx_mode_clr), .irq_clr(irq_clr), .stop_evt(stop_evt),
    .rd_hit(rd_hit), .byte_evt(byte_evt), .ack_evt(ack_evt), .ack_val(ack_val),
    .data_q(data_q), .tx_mode(tx_mode), .byte_irq(byte_irq), .peer_nack(peer_nack)
  );

  assign host_rdata = data_q;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_cur,
  input logic scl_rise,
  input logic start_evt,
  input logic stop_evt,
  input logic rd_hit,
  input logic byte_evt,
  input logic host_rd,
  input logic scl_oe,
  input logic sda_oe,
  input logic tx_mode,
  input logic byte_irq,
  input logic peer_nack
);
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!scl_oe && !sda_oe && !tx_mode));

  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_cur));

  a_r6_irq_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_irq) |-> $past(byte_evt));

  a_r2_mode_from_read_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mode) |-> $past(rd_hit));

  a_r7_ack_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(peer_nack) |-> $past(scl_rise));

  a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(start_evt || stop_evt || host_rd || !byte_irq));
endmodule

bind i2c_slave_tx i2cs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_cur(scl_cur), .scl_rise(scl_rise),
  .start_evt(start_evt), .stop_evt(stop_evt), .rd_hit(rd_hit),
  .byte_evt(byte_evt), .host_rd(host_rd), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .tx_mode(tx_mode), .byte_irq(byte_irq), .peer_nack(peer_nack)
);

// File: tb/sim_i2c_slave_tx.sv
`timescale 1ns/1ps
module sim_i2c_slave_tx;
  localparam int HP = 16;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic m_scl_low, m_sda_low;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe;
  logic host_wr, host_rd, tx_mode_clr, irq_clr;
  logic [7:0] host_wdata, host_rdata;
  logic tx_mode, byte_irq, peer_nack;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_slave_tx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .tx_mode_clr(tx_mode_clr), .tx_mode(tx_mode),
    .byte_irq(byte_irq), .irq_clr(irq_clr), .peer_nack(peer_nack)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- master model ----------------
  task automatic scl_up();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; cyc(HP);
    scl_up(); cyc(HP);
    m_sda_low = 1'b1; cyc(HP);
    m_scl_low = 1'b1; cyc(HP);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; cyc(HP);
    scl_up(); cyc(HP);
    m_sda_low = 1'b0; cyc(HP);
  endtask

  task automatic m_bit_write(input bit b);
    m_sda_low = ~b; cyc(HP);
    scl_up(); cyc(HP);
    m_scl_low = 1'b1; cyc(HP);
  endtask

  task automatic m_bit_read(output bit b);
    m_sda_low = 1'b0; cyc(HP);
    scl_up(); cyc(HP);
    b = sda_line;
    m_scl_low = 1'b1; cyc(HP);
  endtask

  task automatic m_send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit_write(v[i]);
  endtask

  task automatic m_recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      m_bit_read(b);
      v[i] = b;
    end
  endtask

  task automatic m_addr(input logic [6:0] a, input bit rw, output bit ack);
    m_start();
    m_send_byte({a, rw});
    m_bit_read(ack);
  endtask

  // ---------------- host strobes ----------------
  task automatic h_write(input logic [7:0] v);
    host_wdata = v; host_wr = 1'b1; cyc(1); host_wr = 1'b0; cyc(1);
  endtask
  task automatic h_clr_irq();
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(1);
  endtask
  task automatic h_rd();
    host_rd = 1'b1; cyc(1); host_rd = 1'b0; cyc(1);
  endtask
  task automatic h_clr_mode();
    tx_mode_clr = 1'b1; cyc(1); tx_mode_clr = 1'b0; cyc(1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(tx_mode == 1'b0 && byte_irq == 1'b0, "R1 mode/irq clear", {tx_mode, byte_irq}, 0);
  endtask

  task automatic t_read_two();
    bit ack;
    logic [7:0] got;
    m_addr(OWN, 1'b1, ack);
    chk(ack == 1'b0, "R2 address acked", ack, 0);
    chk(tx_mode == 1'b1 && byte_irq == 1'b1, "R2 mode+irq set", {tx_mode, byte_irq}, 3);
    chk(scl_oe == 1'b1, "R2 SCL stretched", scl_oe, 1);
    h_write(8'hA5);
    chk(host_rdata == 8'hA5, "R11 readback", host_rdata, 8'hA5);
    h_clr_irq();
    m_recv_byte(got);
    chk(got == 8'hA5, "R5 first byte MSB first", got, 8'hA5);
    m_bit_write(1'b0);
    chk(byte_irq == 1'b1 && scl_oe == 1'b1, "R6 irq+stretch after byte", {byte_irq, scl_oe}, 3);
    chk(peer_nack == 1'b0, "R7 ACK captured", peer_nack, 0);
    h_write(8'h3C);
    h_clr_irq();
    m_recv_byte(got);
    chk(got == 8'h3C, "R6 second byte from register", got, 8'h3C);
    m_bit_write(1'b1);
    chk(peer_nack == 1'b1, "R7 NACK captured", peer_nack, 1);
    h_clr_irq(); cyc(40);
    chk(scl_oe == 1'b1, "R8 irq clear keeps hold", scl_oe, 1);
    h_rd(); cyc(40);
    chk(scl_oe == 1'b1, "R8 read with mode set keeps hold", scl_oe, 1);
    h_clr_mode();
    chk(tx_mode == 1'b0, "R8 mode cleared", tx_mode, 0);
    h_rd(); cyc(2);
    chk(scl_oe == 1'b0, "R8 dummy read releases SCL", scl_oe, 0);
    m_stop();
  endtask

  task automatic t_mismatch();
    bit ack, ack2;
    m_addr(OWN ^ 7'h01, 1'b1, ack);
    chk(ack == 1'b1, "R3 no ack on mismatch", ack, 1);
    chk(byte_irq == 1'b0 && tx_mode == 1'b0 && scl_oe == 1'b0, "R3 stays idle",
        {byte_irq, tx_mode, scl_oe}, 0);
    m_send_byte(8'h00);
    m_bit_read(ack2);
    chk(ack2 == 1'b1 && sda_oe == 1'b0, "R3 later frame ignored", {ack2, sda_oe}, 2);
    m_stop();
  endtask

  task automatic t_write_req();
    bit ack, ack2;
    m_addr(OWN, 1'b0, ack);
    chk(ack == 1'b0, "R4 write address acked", ack, 0);
    chk(tx_mode == 1'b0 && byte_irq == 1'b0 && scl_oe == 1'b0, "R4 no transmit",
        {tx_mode, byte_irq, scl_oe}, 0);
    m_send_byte(8'h55);
    m_bit_read(ack2);
    chk(ack2 == 1'b1, "R4 data byte not acked", ack2, 1);
    m_stop();
  endtask

  task automatic t_stop_mid();
    bit ack, b;
    m_addr(OWN, 1'b1, ack);
    h_write(8'hFF);
    h_clr_irq();
    for (int i = 0; i < 3; i++) m_bit_read(b);
    chk(b == 1'b1, "R5 bit of 0xFF", b, 1);
    m_stop();
    chk(scl_oe == 1'b0 && sda_oe == 1'b0 && tx_mode == 1'b0, "R9 stop releases",
        {scl_oe, sda_oe, tx_mode}, 0);
  endtask

  task automatic t_restart();
    bit ack;
    m_start();
    m_bit_write(1'b1); m_bit_write(1'b0); m_bit_write(1'b0); m_bit_write(1'b1);
    m_addr(OWN, 1'b1, ack);
    chk(ack == 1'b0 && tx_mode == 1'b1, "R10 restart then read", {ack, tx_mode}, 1);
    h_clr_irq();
    h_clr_mode();
    h_rd(); cyc(2);
    chk(scl_oe == 1'b0, "R10 released after end", scl_oe, 0);
    m_stop();
  endtask

  initial begin
    rst_n = 1'b0;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; tx_mode_clr = 1'b0; irq_clr = 1'b0;
    host_wdata = '0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_read_two();
    t_mismatch();
    t_write_req();
    t_stop_mid();
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule